// File: doc/BRIEF.md
# Configurable LED Indicator Controller

This block drives four active-low LED pins from a handful of synchronous status signals: link up, a two-bit speed code, activity, filtered activity, collision and pause. Every pin has its own 8-bit setting that picks a source, optionally flips it, and optionally turns its asserted state into a visible blink. After reset the four settings come from a default parameter, so a board can start with its preferred display and no software involvement. Software can later replace any of the settings through a simple write port with one byte enable per LED.

A single shared counter provides the blink rhythm. It produces equal on and off phases, each 200 ms long by default. The length of a phase is computed from the clock frequency, and a separate parameter can override it with a short count for simulation. When blinking is enabled, a short activity or collision pulse is held until an on phase has ended. As a result, even a one-cycle event lights the LED for at least one visible on phase. The combined link/activity source is a special case with three outcomes: dark with no link, lit steadily with link and no traffic, and blinking with link and traffic.

Top module: `led_indicator_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `led_n` becomes all ones (all LEDs dark) after that edge, and every LED setting returns to the `CFG_DEFAULT` parameter. LED k uses bits [8k+7:8k] of that parameter.
- R2: A setting byte has mode in bits [3:0], invert in bit 4, blink in bit 5, and bits 7:6 reserved with no effect. The mode codes are: 0 link, 1 link at speed code 0, 2 link at speed code 1, 3 link at speed code 2, 4 link/activity, 5 filtered activity, 6 collision, 7 activity, 8 pause, 9 always on, 10 always off. With blink at 0, the LED is lit exactly while the selected source is 1.
- R3: With invert at 1, the selected source is complemented before the blink stage. With blink at 0, this lights the LED while the source is 0.
- R4: A phase counter alternates on and off phases of HALF_TC cycles each, and the first phase after reset is an on phase. For modes 0–3 and 5–8 with blink at 1, an active LED is lit only during on phases and is always dark during off phases.
- R5: With blink at 1, a source pulse of any length is held until the end of the next on phase that finishes after the pulse. A one-cycle pulse that arrives during an off phase therefore lights the LED for that whole following on phase of HALF_TC cycles.
- R6: In mode 4 with blink at 1, the LED is dark while link is 0. It is lit steadily while link is 1 and no held activity exists. It follows the on/off phases while link is 1 and activity is present or held. In mode 4 with blink at 0, the LED shows link.
- R7: Modes 9 (always on) and 10 (always off) ignore the blink bit and hold a constant level, with invert still applied.
- R8: A write with `cfg_we` at 1 updates only the LEDs whose `cfg_be` bit is 1, taking byte k of `cfg_wdata` for LED k. Settings with a 0 enable bit keep their value.
- R9: Mode codes 11–15 act as a constant 0 source that ignores blink, so the LED is dark unless invert is 1.
- R10: `led_n` is registered and active-low (0 means lit). It reflects the status inputs and the setting from one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_be | input | NUM_LED | Per-LED byte enable for the write |
| cfg_wdata | input | 8*NUM_LED | Setting bytes, byte k for LED k |
| st_link | input | 1 | Link up level |
| st_speed | input | 2 | Speed code: 0, 1 or 2 (3 unused) |
| st_act | input | 1 | Activity pulse or level |
| st_filt_act | input | 1 | Filtered activity pulse or level |
| st_col | input | 1 | Collision pulse or level |
| st_pause | input | 1 | Pause state level |
| led_n | output | NUM_LED | Active-low LED pins |

## Verification
The main overlap is between a source pulse and the end of an on phase. When they land in the same cycle, the held flag must reload from the pulse rather than clear. A second overlap is a setting write that lands on a phase boundary, where the old setting decides the output for that edge. Both are provoked by a long random run with a short phase count of 6 cycles, rare activity pulses and occasional random writes, plus a directed single-cycle pulse placed in an off phase. Every pin is compared on each cycle against a bench model built from the requirements, and the directed pulse must yield exactly one full on phase.

// File: rtl/led_ind_pkg.sv
`timescale 1ns/1ps
package led_ind_pkg;

  typedef enum logic [3:0] {
    SRC_LINK     = 4'd0,
    SRC_LINK_S0  = 4'd1,
    SRC_LINK_S1  = 4'd2,
    SRC_LINK_S2  = 4'd3,
    SRC_LINK_ACT = 4'd4,
    SRC_FILT_ACT = 4'd5,
    SRC_COL      = 4'd6,
    SRC_ACT      = 4'd7,
    SRC_PAUSE    = 4'd8,
    SRC_ON       = 4'd9,
    SRC_OFF      = 4'd10
  } led_src_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       blink;
    logic       inv;
    logic [3:0] mode;
  } led_cfg_t;

  localparam int CFG_W = 8;

endpackage

// File: rtl/led_blink_timebase.sv
`timescale 1ns/1ps
module led_blink_timebase #(
  parameter int HALF_TC = 40_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic phase,
  output logic tick
);
  localparam int CW = (HALF_TC > 1) ? $clog2(HALF_TC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      phase <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the phase flips at each terminal count and nowhere else
  a_r4_phase_flip: assert property (@(posedge clk) disable iff (rst)
    tick |=> (phase != $past(phase)));
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/led_cfg_regs.sv
`timescale 1ns/1ps
module led_cfg_regs #(
  parameter int NUM_LED = 4,
  parameter logic [8*NUM_LED-1:0] CFG_DEFAULT = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [NUM_LED-1:0]     cfg_be,
  input  logic [8*NUM_LED-1:0]   cfg_wdata,
  output logic [8*NUM_LED-1:0]   cfg_q
);
  for (genvar k = 0; k < NUM_LED; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[8*k +: 8] <= CFG_DEFAULT[8*k +: 8];
      else if (cfg_we && cfg_be[k])
        cfg_q[8*k +: 8] <= cfg_wdata[8*k +: 8];
    end

    // R8: a lane without its enable keeps its setting
    a_r8_lane_kept: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_be[k]) |=> $stable(cfg_q[8*k +: 8]));
  end

endmodule

// File: rtl/led_channel.sv
`timescale 1ns/1ps
module led_channel
  import led_ind_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cfg,
  input  logic       st_link,
  input  logic [1:0] st_speed,
  input  logic       st_act,
  input  logic       st_filt_act,
  input  logic       st_col,
  input  logic       st_pause,
  input  logic       phase,
  input  logic       tick,
  output logic       led_n
);
  led_cfg_t c;
  logic sel, lvl, is_static, is_la, pulse, held, on, hold_q, hold_d;

  assign c = led_cfg_t'(cfg);

  always_comb begin
    case (c.mode)
      SRC_LINK:     sel = st_link;
      SRC_LINK_S0:  sel = st_link && (st_speed == 2'd0);
      SRC_LINK_S1:  sel = st_link && (st_speed == 2'd1);
      SRC_LINK_S2:  sel = st_link && (st_speed == 2'd2);
      SRC_LINK_ACT: sel = st_link;
      SRC_FILT_ACT: sel = st_filt_act;
      SRC_COL:      sel = st_col;
      SRC_ACT:      sel = st_act;
      SRC_PAUSE:    sel = st_pause;
      SRC_ON:       sel = 1'b1;
      default:      sel = 1'b0;
    endcase
  end

  always_comb begin
    lvl       = sel ^ c.inv;
    is_static = (c.mode >= SRC_ON);
    is_la     = (c.mode == SRC_LINK_ACT);
    pulse     = is_la ? st_act : lvl;
    held      = hold_q | pulse;
    if (is_static || !c.blink) on = lvl;
    else if (is_la)            on = lvl && (!held || phase);
    else                       on = held && phase;
    hold_d = (tick && phase) ? pulse : held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      led_n  <= 1'b1;
    end else begin
      hold_q <= hold_d;
      led_n  <= ~on;
    end
  end

  // R7: static levels regardless of blink
  a_r7_static_off: assert property (@(posedge clk) disable iff (rst)
    (c.mode == SRC_OFF && !c.inv) |=> led_n);
  a_r7_static_on: assert property (@(posedge clk) disable iff (rst)
    (c.mode == SRC_ON && !c.inv) |=> !led_n);
  // R9: unused codes stay dark without invert
  a_r9_unused_dark: assert property (@(posedge clk) disable iff (rst)
    (c.mode > SRC_OFF && !c.inv) |=> led_n);
  // R4: blinking LEDs are dark in off phases
  a_r4_dark_phase: assert property (@(posedge clk) disable iff (rst)
    (c.blink && !phase && !is_static && !is_la) |=> led_n);
  // R6: link/activity with blink is dark without link
  a_r6_no_link: assert property (@(posedge clk) disable iff (rst)
    (is_la && c.blink && !c.inv && !st_link) |=> led_n);

endmodule

// File: rtl/led_indicator_ctrl.sv
`timescale 1ns/1ps
module led_indicator_ctrl #(
  parameter int NUM_LED  = 4,
  parameter int CLK_HZ   = 200_000_000,
  parameter int BLINK_MS = 200,
  parameter int SIM_HALF = 0,
  parameter logic [8*NUM_LED-1:0] CFG_DEFAULT = 32'h2702_0324
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [NUM_LED-1:0]   cfg_be,
  input  logic [8*NUM_LED-1:0] cfg_wdata,
  input  logic                 st_link,
  input  logic [1:0]           st_speed,
  input  logic                 st_act,
  input  logic                 st_filt_act,
  input  logic                 st_col,
  input  logic                 st_pause,
  output logic [NUM_LED-1:0]   led_n
);
  localparam int HALF_TC = (SIM_HALF != 0) ? SIM_HALF : (CLK_HZ / 1000) * BLINK_MS;

  logic                 phase, tick;
  logic [8*NUM_LED-1:0] cfg_q;

  led_blink_timebase #(.HALF_TC(HALF_TC)) u_tb (
    .clk(clk), .rst(rst), .phase(phase), .tick(tick)
  );

  led_cfg_regs #(.NUM_LED(NUM_LED), .CFG_DEFAULT(CFG_DEFAULT)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  for (genvar k = 0; k < NUM_LED; k++) begin : g_ch
    led_channel u_ch (
      .clk(clk), .rst(rst), .cfg(cfg_q[8*k +: 8]),
      .st_link(st_link), .st_speed(st_speed), .st_act(st_act),
      .st_filt_act(st_filt_act), .st_col(st_col), .st_pause(st_pause),
      .phase(phase), .tick(tick), .led_n(led_n[k])
    );
  end

  // R1: reset darkens every pin
  a_r1_reset_dark: assert property (@(posedge clk) rst |=> (led_n == '1));

endmodule

// File: tb/tb_led_indicator_ctrl.sv
`timescale 1ns/1ps
module tb_led_indicator_ctrl;
  localparam int TC = 6;
  localparam logic [31:0] DEF = 32'h2702_0324;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic st_link = 0, st_act = 0, st_filt_act = 0, st_col = 0, st_pause = 0;
  logic [1:0] st_speed = 2'd0;
  logic [3:0] led_n;

  int total = 0, bad = 0;
  string cur_tag = "";

  logic [7:0] m_cfg [4];
  int         m_cnt;
  logic       m_phase;
  logic [3:0] m_hold;
  logic [3:0] m_ledn;

  always #2.5 clk = ~clk;

  led_indicator_ctrl #(.SIM_HALF(TC), .CFG_DEFAULT(DEF)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .st_link(st_link), .st_speed(st_speed), .st_act(st_act),
    .st_filt_act(st_filt_act), .st_col(st_col), .st_pause(st_pause), .led_n(led_n)
  );

  // Returns {hold_next, lit} for one LED from the requirement rules
  function automatic logic [1:0] eval_led(input logic [7:0] c, input logic hold,
                                          input logic ph, input logic tk);
    logic s, lv, stat, la, p, h, lit;
    case (c[3:0])
      4'd0: s = st_link;
      4'd1: s = st_link && st_speed == 2'd0;
      4'd2: s = st_link && st_speed == 2'd1;
      4'd3: s = st_link && st_speed == 2'd2;
      4'd4: s = st_link;
      4'd5: s = st_filt_act;
      4'd6: s = st_col;
      4'd7: s = st_act;
      4'd8: s = st_pause;
      4'd9: s = 1'b1;
      default: s = 1'b0;
    endcase
    lv = s ^ c[4];
    stat = c[3:0] >= 4'd9;
    la = c[3:0] == 4'd4;
    p = la ? st_act : lv;
    h = hold | p;
    if (stat || !c[5]) lit = lv;
    else if (la) lit = lv && (!h || ph);
    else lit = h && ph;
    return {(tk && ph) ? p : h, lit};
  endfunction

  function automatic string auto_tag(input logic [7:0] c);
    if (c[3:0] >= 4'd11) return "R9";
    if (c[3:0] >= 4'd9) return "R7";
    if (c[3:0] == 4'd4 && c[5]) return "R6";
    if (c[5]) return "R4";
    if (c[4]) return "R3";
    return "R2";
  endfunction

  task automatic step();
    logic [1:0] r;
    logic tk;
    if (rst) begin
      m_cnt = 0; m_phase = 1'b1; m_hold = '0; m_ledn = '1;
      for (int k = 0; k < 4; k++) m_cfg[k] = DEF[8*k +: 8];
    end else begin
      tk = (m_cnt == TC - 1);
      for (int k = 0; k < 4; k++) begin
        r = eval_led(m_cfg[k], m_hold[k], m_phase, tk);
        m_hold[k] = r[1];
        m_ledn[k] = ~r[0];
      end
      if (cfg_we)
        for (int k = 0; k < 4; k++) if (cfg_be[k]) m_cfg[k] = cfg_wdata[8*k +: 8];
      if (tk) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      string t;
      t = (cur_tag != "") ? cur_tag : auto_tag(m_cfg[k]);
      total++;
      if (led_n[k] !== m_ledn[k]) begin
        bad++;
        $display("FAIL %s led%0d actual=%b expected=%b t=%0t", t, k, led_n[k], m_ledn[k], $time);
      end
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lit_cnt;
    void'($urandom(32'd1234));
    // R1: reset state
    cur_tag = "R1";
    repeat (3) step();
    total++;
    if (led_n !== 4'hF) begin bad++; $display("FAIL R1 actual=%h expected=f", led_n); end
    rst = 1'b0;
    repeat (3) step();

    // R2 / R10: link at speed code 2 lights LED1 one edge later
    cur_tag = "R10";
    st_link = 1; st_speed = 2'd2;
    step();
    total++;
    if (led_n[1] !== 1'b0) begin bad++; $display("FAIL R10 led1 actual=%b expected=0", led_n[1]); end
    cur_tag = "R2";
    st_speed = 2'd1; repeat (3) step();
    st_speed = 2'd2; repeat (3) step();

    // R6: steady with link and no activity, blinking with activity
    cur_tag = "R6";
    repeat (2*TC) step();
    st_act = 1; repeat (3*TC) step();
    st_act = 0; repeat (3*TC) step();
    st_link = 0; repeat (TC) step();
    st_link = 1;

    // R8: only LED2 is rewritten
    cur_tag = "R8";
    wr(4'b0100, 32'hAB09_CDEF);
    repeat (4) step();

    // R3: inverted activity without blink
    cur_tag = "R3";
    wr(4'b1000, 32'h1700_0000);
    repeat (3) step();
    st_act = 1; repeat (3) step();
    st_act = 0; repeat (2) step();

    // R5: single-cycle pulse in an off phase gives one full on phase
    cur_tag = "R5";
    wr(4'b1000, 32'h2700_0000);
    while (!(m_phase == 1'b0 && m_cnt == 1 && m_hold[3] == 1'b0)) step();
    st_act = 1; step(); st_act = 0;
    lit_cnt = 0;
    for (int i = 0; i < 2*TC; i++) begin
      step();
      if (led_n[3] == 1'b0) lit_cnt++;
    end
    total++;
    if (lit_cnt != TC) begin bad++; $display("FAIL R5 lit cycles actual=%0d expected=%0d", lit_cnt, TC); end

    // R7: static modes ignore blink
    cur_tag = "R7";
    wr(4'b0100, 32'h002A_0000); repeat (2*TC) step();
    wr(4'b0100, 32'h0029_0000); repeat (2*TC) step();
    wr(4'b0100, 32'h0039_0000); repeat (TC) step();

    // R9: unused codes
    cur_tag = "R9";
    wr(4'b0010, 32'h0000_2C00); repeat (TC) step();
    wr(4'b0010, 32'h0000_1F00); repeat (TC) step();

    // R4: pause level blinking
    cur_tag = "R4";
    wr(4'b1000, 32'h2800_0000);
    st_pause = 1; repeat (3*TC) step();
    st_pause = 0; repeat (2*TC) step();

    // random mix, tagged per LED setting
    cur_tag = "";
    for (int i = 0; i < 4000; i++) begin
      st_link = ($urandom % 8) != 0;
      st_speed = 2'($urandom % 4);
      st_act = ($urandom % 10) == 0;
      st_filt_act = ($urandom % 12) == 0;
      st_col = ($urandom % 15) == 0;
      st_pause = ($urandom % 3) == 0;
      if (($urandom % 20) == 0) begin
        cfg_we = 1; cfg_be = 4'($urandom); cfg_wdata = $urandom;
      end else begin
        cfg_we = 0; cfg_be = '0;
      end
      step();
    end
    cfg_we = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule